// File: doc/BRIEF.md
# Floating-point operand unpack and classify

This unit takes a raw 128-bit register operand and a format code, then turns the operand into one wide internal form that later arithmetic stages can consume without caring where it came from. The internal form has a sign, a signed unbiased exponent, a 128-bit mantissa whose leading one sits at bit 124, and a class code. Five source formats are accepted: 32-bit and 64-bit integers, and IEEE single, double and quad precision. Denormals and integers are brought to the normalized form with a leading-zero count followed by a left shift. A signalling NaN is made quiet as it enters, and it is still reported through its class and an invalid-operation flag.

Narrow formats sit in the top bits of the operand, so the sign is always bit 127. Results are registered and appear one clock after the operand and format are applied. Arithmetic, rounding and repacking are handled by other stages.

Top module: `fp_operand_unpack`

## Requirements
- R1: A 32-bit format (int32, single) is taken from operand bits [127:96], and a 64-bit format (int64, double) from bits [127:64]. Quad uses all 128 bits. The sign output is operand bit 127, and operand bits below the selected format have no effect on any output.
- R2: The format codes are 0 = int32, 1 = int64, 2 = single, 3 = double and 4 = quad. Codes 5 to 7 set the illegal-format output and give class 0 (zero), sign 0, exponent 0, mantissa 0 and invalid 0.
- R3: The class codes are 0 zero, 1 number, 2 infinity, 3 quiet NaN and 4 signalling NaN. An IEEE operand whose exponent and fraction are both zero, or an integer equal to zero, gives class 0 with exponent 0 and mantissa 0.
- R4: A normal IEEE operand gives class 1 and exponent = field - bias, where the bias is 127, 1023 or 16383. The mantissa has the implied one at bit 124 and the fraction directly below it, with the most significant fraction bit at bit 123.
- R5: A denormal (zero exponent field, nonzero fraction) gives class 1. Its exponent starts at 1 - bias, with no implied one, and it is normalized: the leading one is moved to bit 124 and the exponent is reduced by the shift distance. For example, the smallest single gives -149, the smallest double -1074 and the smallest quad -16494.
- R6: An all-ones exponent field with a zero fraction gives class 2 (infinity), mantissa 0 and exponent 0.
- R7: An all-ones exponent field with a nonzero fraction whose top bit is set gives class 3 (quiet NaN). The fraction is kept at its aligned position, with no implied one and no normalization, the exponent is 0 and the invalid flag is 0.
- R8: An all-ones exponent field with a nonzero fraction whose top bit is clear gives class 4 (signalling NaN). Mantissa bit 123 is forced to 1, the remaining fraction bits stay in place, and the invalid flag is 1. The invalid flag is 0 for every other input.
- R9: An integer whose top bit is set is converted to its two's complement magnitude and the sign output is 1; otherwise the integer is unsigned. A nonzero integer gives class 1, with the leading one of the magnitude moved to bit 124 and the exponent set to that leading one's bit index in the magnitude (int32 0x80000000 gives exponent 31).
- R10: Outputs are registered and change one clock after the inputs. While reset is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_i | input | 128 | Raw operand; narrow formats left-aligned |
| fmt_i | input | 3 | Format code |
| sign_o | output | 1 | Sign of the unpacked value |
| exp_o | output | EXP_W (18) | Signed unbiased exponent |
| mant_o | output | MANT_W (128) | Mantissa, leading one at bit LEAD (124) |
| cls_o | output | 3 | Class code |
| invalid_o | output | 1 | Invalid operation: signalling NaN seen |
| badfmt_o | output | 1 | Format code outside 0 to 4 |

## Verification
The bench targets the smallest denormal of each IEEE width, where a normalizer that counts from the wrong bit or misses the final step would give an exponent off by one or more, or a mantissa without its leading one at bit 124. It also drives the largest normals, infinities of both signs, and quiet and signalling NaNs. A design that normalized NaNs, inserted an implied one into them, or failed to quiet them would show the wrong mantissa, class or invalid flag. The most negative integers and all-ones integers test the negation path, where a missed or doubled negation changes the exponent or mantissa. Junk in the unused low operand bits and the illegal format codes catch slicing and decode mistakes.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;

   typedef enum logic [2:0] {
      CLS_ZERO = 3'd0,
      CLS_NUM  = 3'd1,
      CLS_INF  = 3'd2,
      CLS_QNAN = 3'd3,
      CLS_SNAN = 3'd4
   } fp_class_e;

   typedef enum logic [2:0] {
      FMT_I32  = 3'd0,
      FMT_I64  = 3'd1,
      FMT_SGL  = 3'd2,
      FMT_DBL  = 3'd3,
      FMT_QUAD = 3'd4
   } fp_fmt_e;

   localparam int NUM_IEEE = 3;
   localparam int NUM_INT  = 2;

   // index 0 single, 1 double, 2 quad
   function automatic int ieee_exp_bits(int idx);
      case (idx)
         0:       return 8;
         1:       return 11;
         default: return 15;
      endcase
   endfunction

   function automatic int ieee_frac_bits(int idx);
      case (idx)
         0:       return 23;
         1:       return 52;
         default: return 112;
      endcase
   endfunction

   // index 0 int32, 1 int64
   function automatic int int_bits(int idx);
      return (idx == 0) ? 32 : 64;
   endfunction

endpackage

// File: rtl/fp_ieee_decode.sv
module fp_ieee_decode
   import fpu_unpack_pkg::*;
#(
   parameter int EXP_BITS  = 8,
   parameter int FRAC_BITS = 23,
   parameter int MANT_W    = 128,
   parameter int LEAD      = 124,
   parameter int EXP_W     = 18,
   localparam int WORD_W   = 1 + EXP_BITS + FRAC_BITS
) (
   input  logic [WORD_W-1:0]       word_i,
   output logic [2:0]              cls_o,
   output logic signed [EXP_W-1:0] exp_o,
   output logic [MANT_W-1:0]       mant_o
);
   localparam int BIAS   = (1 << (EXP_BITS - 1)) - 1;
   localparam int FSHIFT = LEAD - FRAC_BITS;

   logic [EXP_BITS-1:0]  efield;
   logic [FRAC_BITS-1:0] frac;
   logic [MANT_W-1:0]    frac_al;
   logic [MANT_W-1:0]    lead_one;
   logic [MANT_W-1:0]    quiet_one;

   assign efield    = word_i[WORD_W-2 -: EXP_BITS];
   assign frac      = word_i[FRAC_BITS-1:0];
   assign frac_al   = MANT_W'(frac) << FSHIFT;
   assign lead_one  = MANT_W'(1) << LEAD;
   assign quiet_one = MANT_W'(1) << (LEAD - 1);

   always_comb begin
      cls_o  = CLS_NUM;
      exp_o  = '0;
      mant_o = '0;
      if (efield == '0) begin
         if (frac == '0) begin
            cls_o = CLS_ZERO;
         end else begin
            exp_o  = EXP_W'(1 - BIAS);
            mant_o = frac_al;
         end
      end else if (&efield) begin
         if (frac == '0) begin
            cls_o = CLS_INF;
         end else begin
            mant_o = frac_al | quiet_one;
            cls_o  = frac[FRAC_BITS-1] ? CLS_QNAN : CLS_SNAN;
         end
      end else begin
         exp_o  = EXP_W'(efield) - EXP_W'(BIAS);
         mant_o = frac_al | lead_one;
      end
   end

endmodule

// File: rtl/fp_int_decode.sv
module fp_int_decode
   import fpu_unpack_pkg::*;
#(
   parameter int INT_W  = 32,
   parameter int MANT_W = 128,
   parameter int LEAD   = 124,
   parameter int EXP_W  = 18
) (
   input  logic [INT_W-1:0]        val_i,
   output logic [2:0]              cls_o,
   output logic signed [EXP_W-1:0] exp_o,
   output logic [MANT_W-1:0]       mant_o
);
   localparam int PLACE = LEAD - INT_W + 1;

   logic [INT_W-1:0] mag;

   assign mag = val_i[INT_W-1] ? (~val_i + INT_W'(1)) : val_i;

   always_comb begin
      if (val_i == '0) begin
         cls_o  = CLS_ZERO;
         exp_o  = '0;
         mant_o = '0;
      end else begin
         cls_o  = CLS_NUM;
         exp_o  = EXP_W'(INT_W - 1);
         mant_o = MANT_W'(mag) << PLACE;
      end
   end

endmodule

// File: rtl/fp_normalize.sv
module fp_normalize #(
   parameter int MANT_W = 128,
   parameter int LEAD   = 124,
   parameter int EXP_W  = 18,
   localparam int CNT_W = $clog2(LEAD + 2)
) (
   input  logic                    en_i,
   input  logic [MANT_W-1:0]       mant_i,
   input  logic signed [EXP_W-1:0] exp_i,
   output logic [MANT_W-1:0]       mant_o,
   output logic signed [EXP_W-1:0] exp_o
);
   logic [CNT_W-1:0] lz;

   // highest set bit at or below LEAD wins (last assignment)
   always_comb begin
      lz = '0;
      for (int b = 0; b <= LEAD; b++) begin
         if (mant_i[b]) lz = CNT_W'(LEAD - b);
      end
   end

   assign mant_o = en_i ? (mant_i << lz) : mant_i;
   assign exp_o  = en_i ? (exp_i - EXP_W'(lz)) : exp_i;

endmodule

// File: rtl/fp_operand_unpack.sv
module fp_operand_unpack
   import fpu_unpack_pkg::*;
#(
   parameter int OPND_W = 128,
   parameter int MANT_W = 128,
   parameter int LEAD   = 124,
   parameter int EXP_W  = 18
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [OPND_W-1:0]       opnd_i,
   input  logic [2:0]              fmt_i,
   output logic                    sign_o,
   output logic signed [EXP_W-1:0] exp_o,
   output logic [MANT_W-1:0]       mant_o,
   output logic [2:0]              cls_o,
   output logic                    invalid_o,
   output logic                    badfmt_o
);
   localparam int WIDEST_FRAC = 112;

   if (OPND_W != 128) begin : g_bad_opnd
      $error("OPND_W must be 128");
   end
   if (LEAD < WIDEST_FRAC + 1) begin : g_bad_lead
      $error("LEAD too small for the quad fraction");
   end
   if (MANT_W <= LEAD) begin : g_bad_mant
      $error("MANT_W must exceed LEAD");
   end
   if (EXP_W < 16) begin : g_bad_exp
      $error("EXP_W too small for quad denormals");
   end

   logic [2:0]              ie_cls  [NUM_IEEE];
   logic signed [EXP_W-1:0] ie_exp  [NUM_IEEE];
   logic [MANT_W-1:0]       ie_mant [NUM_IEEE];
   logic [2:0]              in_cls  [NUM_INT];
   logic signed [EXP_W-1:0] in_exp  [NUM_INT];
   logic [MANT_W-1:0]       in_mant [NUM_INT];

   for (genvar g = 0; g < NUM_IEEE; g++) begin : g_ieee
      localparam int EB = ieee_exp_bits(g);
      localparam int FB = ieee_frac_bits(g);
      localparam int W  = 1 + EB + FB;
      fp_ieee_decode #(
         .EXP_BITS(EB), .FRAC_BITS(FB), .MANT_W(MANT_W), .LEAD(LEAD), .EXP_W(EXP_W)
      ) u_dec (
         .word_i (opnd_i[OPND_W-1 -: W]),
         .cls_o  (ie_cls[g]),
         .exp_o  (ie_exp[g]),
         .mant_o (ie_mant[g])
      );
   end

   for (genvar g = 0; g < NUM_INT; g++) begin : g_int
      localparam int IW = int_bits(g);
      fp_int_decode #(
         .INT_W(IW), .MANT_W(MANT_W), .LEAD(LEAD), .EXP_W(EXP_W)
      ) u_dec (
         .val_i  (opnd_i[OPND_W-1 -: IW]),
         .cls_o  (in_cls[g]),
         .exp_o  (in_exp[g]),
         .mant_o (in_mant[g])
      );
   end

   logic [2:0]              sel_cls;
   logic signed [EXP_W-1:0] sel_exp;
   logic [MANT_W-1:0]       sel_mant;
   logic                    sel_bad;

   always_comb begin
      sel_cls  = CLS_ZERO;
      sel_exp  = '0;
      sel_mant = '0;
      sel_bad  = 1'b0;
      case (fmt_i)
         FMT_I32:  begin sel_cls = in_cls[0]; sel_exp = in_exp[0]; sel_mant = in_mant[0]; end
         FMT_I64:  begin sel_cls = in_cls[1]; sel_exp = in_exp[1]; sel_mant = in_mant[1]; end
         FMT_SGL:  begin sel_cls = ie_cls[0]; sel_exp = ie_exp[0]; sel_mant = ie_mant[0]; end
         FMT_DBL:  begin sel_cls = ie_cls[1]; sel_exp = ie_exp[1]; sel_mant = ie_mant[1]; end
         FMT_QUAD: begin sel_cls = ie_cls[2]; sel_exp = ie_exp[2]; sel_mant = ie_mant[2]; end
         default:  sel_bad = 1'b1;
      endcase
   end

   logic [MANT_W-1:0]       nrm_mant;
   logic signed [EXP_W-1:0] nrm_exp;

   fp_normalize #(
      .MANT_W(MANT_W), .LEAD(LEAD), .EXP_W(EXP_W)
   ) u_norm (
      .en_i   (sel_cls == CLS_NUM),
      .mant_i (sel_mant),
      .exp_i  (sel_exp),
      .mant_o (nrm_mant),
      .exp_o  (nrm_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sign_o    <= 1'b0;
         exp_o     <= '0;
         mant_o    <= '0;
         cls_o     <= CLS_ZERO;
         invalid_o <= 1'b0;
         badfmt_o  <= 1'b0;
      end else begin
         sign_o    <= opnd_i[OPND_W-1] & ~sel_bad;
         exp_o     <= nrm_exp;
         mant_o    <= nrm_mant;
         cls_o     <= sel_cls;
         invalid_o <= (sel_cls == CLS_SNAN);
         badfmt_o  <= sel_bad;
      end
   end

endmodule

// File: rtl/fp_operand_unpack_chk.sv
module fp_operand_unpack_chk
   import fpu_unpack_pkg::*;
#(
   parameter int MANT_W = 128,
   parameter int LEAD   = 124,
   parameter int EXP_W  = 18
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic signed [EXP_W-1:0] exp_o,
   input logic [MANT_W-1:0]       mant_o,
   input logic [2:0]              cls_o,
   input logic                    invalid_o,
   input logic                    badfmt_o
);
   logic [MANT_W-1:0] above_lead;
   assign above_lead = mant_o >> (LEAD + 1);

   a_r3_class_legal: assert property (@(posedge clk) disable iff (!rst_n)
      cls_o <= 3'd4);

   a_r3_zero_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_o == 3'(CLS_ZERO)) |-> (mant_o == '0 && exp_o == '0));

   a_r5_num_normalized: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_o == 3'(CLS_NUM)) |-> (mant_o[LEAD] && above_lead == '0));

   a_r6_inf_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_o == 3'(CLS_INF)) |-> (mant_o == '0 && exp_o == '0));

   a_r7_nan_quiet_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_o == 3'(CLS_QNAN) || cls_o == 3'(CLS_SNAN)) |-> (mant_o[LEAD-1] && !mant_o[LEAD]));

   a_r8_invalid_only_snan: assert property (@(posedge clk) disable iff (!rst_n)
      invalid_o == (cls_o == 3'(CLS_SNAN)));

   a_r2_badfmt_zero: assert property (@(posedge clk) disable iff (!rst_n)
      badfmt_o |-> (cls_o == 3'(CLS_ZERO) && !invalid_o));

endmodule

bind fp_operand_unpack fp_operand_unpack_chk #(
   .MANT_W(MANT_W), .LEAD(LEAD), .EXP_W(EXP_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .exp_o     (exp_o),
   .mant_o    (mant_o),
   .cls_o     (cls_o),
   .invalid_o (invalid_o),
   .badfmt_o  (badfmt_o)
);

// File: tb/fp_operand_unpack_bench.sv
module fp_operand_unpack_bench;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [127:0]       opnd_i = '0;
   logic [2:0]         fmt_i = '0;
   logic               sign_o;
   logic signed [17:0] exp_o;
   logic [127:0]       mant_o;
   logic [2:0]         cls_o;
   logic               invalid_o;
   logic               badfmt_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fp_operand_unpack u_fp_operand_unpack (
      .clk(clk), .rst_n(rst_n), .opnd_i(opnd_i), .fmt_i(fmt_i),
      .sign_o(sign_o), .exp_o(exp_o), .mant_o(mant_o), .cls_o(cls_o),
      .invalid_o(invalid_o), .badfmt_o(badfmt_o)
   );

   function automatic logic [127:0] bit_at(int n);
      return 128'(1) << n;
   endfunction

   task automatic expect_out(string req, bit s, int e, logic [127:0] m,
                             logic [2:0] c, bit inv, bit bad);
      checks++;
      if (sign_o !== s || exp_o !== 18'(e) || mant_o !== m || cls_o !== c ||
          invalid_o !== inv || badfmt_o !== bad) begin
         errors++;
         $display("FAIL %s: got s=%0b e=%0d m=%h c=%0d inv=%0b bad=%0b, expected s=%0b e=%0d m=%h c=%0d inv=%0b bad=%0b",
                  req, sign_o, exp_o, mant_o, cls_o, invalid_o, badfmt_o,
                  s, e, m, c, inv, bad);
      end
   endtask

   // drive at a falling edge, sample one full clock later
   task automatic apply(logic [127:0] op, logic [2:0] f);
      @(negedge clk);
      opnd_i = op;
      fmt_i  = f;
      @(negedge clk);
   endtask

   task automatic t_reset();
      opnd_i = {32'h7F800001, 96'h0};
      fmt_i  = 3'd2;
      @(negedge clk);
      expect_out("R10 reset", 0, 0, '0, 3'd0, 0, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_single();
      apply({32'h00000000, 96'h0}, 3'd2);
      expect_out("R3 single +0", 0, 0, '0, 3'd0, 0, 0);
      apply({32'h80000000, 96'h0}, 3'd2);
      expect_out("R3 single -0", 1, 0, '0, 3'd0, 0, 0);
      apply({32'h3F800000, 96'h0}, 3'd2);
      expect_out("R4 single 1.0", 0, 0, bit_at(124), 3'd1, 0, 0);
      apply({32'h7F7FFFFF, 96'h0}, 3'd2);
      expect_out("R4 single max", 0, 127, bit_at(124) | (128'h7FFFFF << 101), 3'd1, 0, 0);
      apply({32'h00000001, 96'h0}, 3'd2);
      expect_out("R5 single min denormal", 0, -149, bit_at(124), 3'd1, 0, 0);
      apply({32'hFF800000, 96'h0}, 3'd2);
      expect_out("R6 single -inf", 1, 0, '0, 3'd2, 0, 0);
   endtask

   task automatic t_double();
      apply({64'h3FF8000000000000, 64'h0}, 3'd3);
      expect_out("R4 double 1.5", 0, 0, bit_at(124) | bit_at(123), 3'd1, 0, 0);
      apply({$realtobits(-3.0), 64'h0}, 3'd3);
      expect_out("R4 double -3.0", 1, 1, bit_at(124) | bit_at(123), 3'd1, 0, 0);
      apply({64'h7FEFFFFFFFFFFFFF, 64'h0}, 3'd3);
      expect_out("R4 double max", 0, 1023,
                 bit_at(124) | (128'h000FFFFFFFFFFFFF << 72), 3'd1, 0, 0);
      apply({64'h0000000000000001, 64'h0}, 3'd3);
      expect_out("R5 double min denormal", 0, -1074, bit_at(124), 3'd1, 0, 0);
      apply({64'h7FF0000000000000, 64'h0}, 3'd3);
      expect_out("R6 double +inf", 0, 0, '0, 3'd2, 0, 0);
   endtask

   task automatic t_quad();
      apply({16'h3FFF, 112'h0}, 3'd4);
      expect_out("R4 quad 1.0", 0, 0, bit_at(124), 3'd1, 0, 0);
      apply(128'h1, 3'd4);
      expect_out("R5 quad min denormal", 0, -16494, bit_at(124), 3'd1, 0, 0);
      apply({16'hFFFF, 112'h0}, 3'd4);
      expect_out("R6 quad -inf", 1, 0, '0, 3'd2, 0, 0);
   endtask

   task automatic t_nan();
      apply({32'h7FC00000, 96'h0}, 3'd2);
      expect_out("R7 single qnan", 0, 0, bit_at(123), 3'd3, 0, 0);
      apply({16'h7FFF, 1'b1, 111'h0}, 3'd4);
      expect_out("R7 quad qnan", 0, 0, bit_at(123), 3'd3, 0, 0);
      apply({32'h7F800001, 96'h0}, 3'd2);
      expect_out("R8 single snan", 0, 0, bit_at(123) | bit_at(101), 3'd4, 1, 0);
      apply({64'hFFF0000000000001, 64'h0}, 3'd3);
      expect_out("R8 double snan", 1, 0, bit_at(123) | bit_at(72), 3'd4, 1, 0);
   endtask

   task automatic t_int();
      apply({32'd0, 96'h0}, 3'd0);
      expect_out("R3 int32 zero", 0, 0, '0, 3'd0, 0, 0);
      apply({32'd1, 96'h0}, 3'd0);
      expect_out("R9 int32 1", 0, 0, bit_at(124), 3'd1, 0, 0);
      apply({32'h80000000, 96'h0}, 3'd0);
      expect_out("R9 int32 most negative", 1, 31, bit_at(124), 3'd1, 0, 0);
      apply({32'hFFFFFFFF, 96'h0}, 3'd0);
      expect_out("R9 int32 -1", 1, 0, bit_at(124), 3'd1, 0, 0);
      apply({64'h8000000000000000, 64'h0}, 3'd1);
      expect_out("R9 int64 most negative", 1, 63, bit_at(124), 3'd1, 0, 0);
      apply({64'h7FFFFFFFFFFFFFFF, 64'h0}, 3'd1);
      expect_out("R9 int64 max", 0, 62, 128'h7FFFFFFFFFFFFFFF << 62, 3'd1, 0, 0);
   endtask

   task automatic t_ignore();
      apply({32'h3F800000, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF}, 3'd2);
      expect_out("R1 single low bits ignored", 0, 0, bit_at(124), 3'd1, 0, 0);
      apply({32'd6, 96'hA5A5_A5A5_A5A5_A5A5_A5A5_A5A5}, 3'd0);
      expect_out("R1 int32 low bits ignored", 0, 2, bit_at(124) | bit_at(123), 3'd1, 0, 0);
      apply({64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, 3'd3);
      expect_out("R1 double low bits ignored", 0, 0, '0, 3'd0, 0, 0);
   endtask

   task automatic t_badfmt();
      apply({32'hFF800001, 96'h1}, 3'd5);
      expect_out("R2 format 5", 0, 0, '0, 3'd0, 0, 1);
      apply({32'h3F800000, 96'h0}, 3'd7);
      expect_out("R2 format 7", 0, 0, '0, 3'd0, 0, 1);
      apply({32'h3F800000, 96'h0}, 3'd2);
      expect_out("R2 legal format after illegal", 0, 0, bit_at(124), 3'd1, 0, 0);
   endtask

   initial begin
      t_reset();
      t_single();
      t_double();
      t_quad();
      t_nan();
      t_int();
      t_ignore();
      t_badfmt();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R10 watchdog: got hung run, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule